// File: doc/BRIEF.md
# Bus Transfer Size and Misalignment Splitter

This block stands between a load/store unit and a 64-bit external data bus. It takes one access at a time: a size of one, two, four or eight bytes, a byte address, a direction, and a flag that marks a floating-point operand. For each access it issues the bus transfer(s). Each transfer carries a three-bit size code, the full address whose low three bits name the first byte lane, and an eight-bit lane enable. Write data moves from a right-justified operand onto the byte lanes. Read data comes back from the lanes into a right-justified, zero-extended operand.

An access whose bytes all fall inside one 32-bit word goes out as a single transfer, even at an unaligned address. An access that runs across a 32-bit word boundary becomes two transfers. The lower-addressed part goes first, and the requester sees a single completion. A floating-point operand that is not word-aligned is refused with an alignment flag and causes no bus activity. So is an eight-byte operand that is not word-aligned. The requester side uses a valid/ready handshake with a one-cycle completion pulse. The bus side uses a valid/ready handshake per transfer.

Top module: `bus_size_splitter`

## Requirements
- R1: The bus size code equals the byte count of the transfer modulo 8: 001 one byte, 010 two bytes, 011 three bytes, 100 four bytes, 000 eight bytes. The number of enabled lanes equals that count.
- R2: Lane i carries the byte at address offset i within the 8-byte bus word, on bus data bits [63-8i:56-8i]. The low three bits of the bus address name the first enabled lane, and the enabled lanes are contiguous from there.
- R3: A 1-, 2- or 4-byte access whose bytes lie in one 32-bit word, and an 8-byte access at offset 0, produce exactly one transfer at the request address. A transfer of fewer than eight bytes never enables lanes on both sides of the lane 3/4 boundary.
- R4: Any other accepted access produces exactly two transfers. The first is at the request address and carries the bytes up to the next 32-bit word boundary. The second is at that boundary address and carries the rest.
- R5: A floating-point access, or an 8-byte access, whose address bits [1:0] are not 00 completes in the cycle after acceptance with the alignment flag set and makes no bus transfer. Every other access completes with the flag clear.
- R6: Write operands are right-justified in the request data, with the most significant operand byte at the lowest address. Each byte goes out on the lane that matches its address.
- R7: Read results are right-justified and zero-extended, with the lowest-addressed byte most significant. They are assembled from both parts of a split access and returned with a completion pulse exactly one cycle long, after the last transfer.
- R8: The requester ready is low from the cycle after an acceptance until the cycle after the completion pulse, so one access is handled at a time.
- R9: While a bus transfer is waiting for the bus ready, its address, size code, lane enables and write data stay unchanged.
- R10: During reset, requester ready, bus valid and completion are all low. Requester ready rises within three cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_fp | input | 1 | Operand is floating-point |
| req_size | input | 2 | 0 one byte, 1 two bytes, 2 four bytes, 3 eight bytes |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | 64 | Right-justified store operand |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_align_err | output | 1 | Access refused for alignment (valid with rsp_valid) |
| rsp_rdata | output | 64 | Right-justified load result (valid with rsp_valid) |
| bus_valid | output | 1 | Bus transfer request |
| bus_ready | input | 1 | Bus accepts the current transfer |
| bus_write | output | 1 | Transfer direction |
| bus_addr | output | ADDR_W | Transfer address |
| bus_tsize | output | 3 | Transfer size code |
| bus_lanes | output | 8 | Byte-lane enables, bit i = lane i |
| bus_wdata | output | 64 | Store data on the lanes |
| bus_rdata | input | 64 | Load data from the lanes |

## Verification
A wrong internal state shows up at the bus within the same transfer. A bad split decision or lane plan changes the size code, the lane mask or the number of transfers before the completion pulse. The bench records every transfer and compares it with the expected list for every size at every offset. Lanes or byte indices that are off by one corrupt a byte on the bus. That shows up on the read-back of the same address a few cycles later, because a reference byte memory is kept apart from the bus memory and unused lanes return junk. A sequencer stuck in a busy state shows up as a missing completion or a requester ready that never returns.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int BUS_LANES  = 8;
  localparam int DATA_W     = BUS_LANES * 8;
  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_TAIL = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  // one bus beat: first lane, byte count, index of its first operand byte
  typedef struct packed {
    logic [2:0] lane;
    logic [3:0] cnt;
    logic [3:0] first;
  } beat_plan_t;

  function automatic logic [3:0] size_to_bytes(acc_size_e s);
    return 4'd1 << s;
  endfunction
endpackage

// File: rtl/bss_plan.sv
module bss_plan
  import bss_pkg::*;
(
  input  acc_size_e  size_i,
  input  logic       fp_i,
  input  logic [2:0] off_i,
  output logic       refuse_o,
  output logic       split_o,
  output logic [3:0] total_o,
  output beat_plan_t head_o,
  output beat_plan_t tail_o
);
  logic [3:0] head_cnt;
  logic [3:0] reach;

  always_comb begin
    total_o  = size_to_bytes(size_i);
    head_cnt = 4'(WORD_BYTES) - {2'b00, off_i[1:0]};
    reach    = {2'b00, off_i[1:0]} + total_o;
    refuse_o = (fp_i || size_i == SZ_DWORD) && (off_i[1:0] != 2'b00);
    // eight-byte operands split only at the middle of the bus word
    split_o  = (size_i == SZ_DWORD) ? off_i[2] : (reach > 4'(WORD_BYTES));

    head_o.lane  = off_i;
    head_o.cnt   = split_o ? head_cnt : total_o;
    head_o.first = 4'd0;

    tail_o.lane  = off_i[2] ? 3'd0 : 3'd4;
    tail_o.cnt   = total_o - head_cnt;
    tail_o.first = head_cnt;
  end
endmodule

// File: rtl/bss_wr_pack.sv
module bss_wr_pack
  import bss_pkg::*;
(
  input  beat_plan_t          beat_i,
  input  logic [3:0]          total_i,
  input  logic [DATA_W-1:0]   opnd_i,
  output logic [BUS_LANES-1:0] lanes_o,
  output logic [DATA_W-1:0]   data_o
);
  always_comb begin
    lanes_o = '0;
    data_o  = '0;
    for (int i = 0; i < BUS_LANES; i++) begin
      logic [4:0] rel;
      logic       act;
      logic [3:0] idx;
      logic [2:0] pos;
      rel = 5'(i) - {2'b00, beat_i.lane};
      act = (5'(i) >= {2'b00, beat_i.lane}) && (rel < {1'b0, beat_i.cnt});
      idx = beat_i.first + rel[3:0];
      pos = 3'(total_i - 4'd1 - idx);
      lanes_o[i] = act;
      // unused lanes are driven to zero
      data_o[8*(BUS_LANES-1-i) +: 8] = act ? opnd_i[8*pos +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/bss_rd_merge.sv
module bss_rd_merge
  import bss_pkg::*;
(
  input  beat_plan_t        beat_i,
  input  logic [3:0]        total_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [DATA_W-1:0] acc_o
);
  always_comb begin
    acc_o = acc_i;
    for (int p = 0; p < BUS_LANES; p++) begin
      logic [3:0] j;
      logic [2:0] rel;
      logic [2:0] lane;
      logic       hit;
      j    = total_i - 4'd1 - 4'(p);
      hit  = (4'(p) < total_i) && (j >= beat_i.first) &&
             (j < beat_i.first + beat_i.cnt);
      rel  = 3'(j - beat_i.first);
      lane = beat_i.lane + rel;
      if (hit) acc_o[8*p +: 8] = rdata_i[8*(3'd7 - lane) +: 8];
    end
  end
endmodule

// File: rtl/bus_size_splitter.sv
module bus_size_splitter
  import bss_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_fp,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_align_err,
  output logic [63:0]       rsp_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_tsize,
  output logic [7:0]        bus_lanes,
  output logic [63:0]       bus_wdata,
  input  logic [63:0]       bus_rdata
);
  localparam logic [ADDR_W-3:0] WORD_STEP = (ADDR_W-2)'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  acc_size_e         size_q;
  logic              fp_q, write_q, err_q, err_d;
  logic [DATA_W-1:0] wdata_q, acc_q, acc_d, merged;
  logic              ld_req, acc_en;

  logic       idle, accept, bus_fire;
  acc_size_e  p_size;
  logic       p_fp;
  logic [2:0] p_off;
  logic       refuse, split;
  logic [3:0] total;
  beat_plan_t head, tail, beat_sel;

  assign idle     = (state_q == ST_IDLE);
  assign req_ready = idle && rst_ok;
  assign accept   = req_valid && req_ready;
  assign bus_valid = (state_q == ST_HEAD) || (state_q == ST_TAIL);
  assign bus_fire = bus_valid && bus_ready;

  // the planner looks at the incoming request while idle, else at the held one
  assign p_size = idle ? acc_size_e'(req_size) : size_q;
  assign p_fp   = idle ? req_fp : fp_q;
  assign p_off  = idle ? req_addr[2:0] : addr_q[2:0];

  bss_plan plan_i (
    .size_i   (p_size),
    .fp_i     (p_fp),
    .off_i    (p_off),
    .refuse_o (refuse),
    .split_o  (split),
    .total_o  (total),
    .head_o   (head),
    .tail_o   (tail)
  );

  assign beat_sel = (state_q == ST_TAIL) ? tail : head;

  bss_wr_pack pack_i (
    .beat_i  (beat_sel),
    .total_i (total),
    .opnd_i  (wdata_q),
    .lanes_o (bus_lanes),
    .data_o  (bus_wdata)
  );

  bss_rd_merge merge_i (
    .beat_i  (beat_sel),
    .total_i (total),
    .rdata_i (bus_rdata),
    .acc_i   (acc_q),
    .acc_o   (merged)
  );

  // next-state and enables
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)   state_d = refuse ? ST_DONE : ST_HEAD;
      ST_HEAD: if (bus_fire) state_d = split ? ST_TAIL : ST_DONE;
      ST_TAIL: if (bus_fire) state_d = ST_DONE;
      ST_DONE:               state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
    ld_req = accept;
    err_d  = refuse;
    acc_en = accept || (bus_fire && !write_q);
    acc_d  = accept ? '0 : merged;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= SZ_BYTE;
      fp_q    <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
      err_q   <= 1'b0;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ld_req) begin
        addr_q  <= req_addr;
        size_q  <= acc_size_e'(req_size);
        fp_q    <= req_fp;
        write_q <= req_write;
        wdata_q <= req_wdata;
        err_q   <= err_d;
      end
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign bus_write     = write_q;
  assign bus_addr      = (state_q == ST_TAIL) ?
                         {addr_q[ADDR_W-1:2] + WORD_STEP, 2'b00} : addr_q;
  assign bus_tsize     = beat_sel.cnt[2:0];
  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_align_err = rsp_valid && err_q;
  assign rsp_rdata     = acc_q;

  // ---------------- assertions ----------------
  assert_lane_count_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    bus_valid |-> ($countones(bus_lanes) ==
                   ((bus_tsize == 3'd0) ? 32'd8 : {29'd0, bus_tsize})));

  assert_first_lane_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    bus_valid |-> bus_lanes[bus_addr[2:0]]);

  assert_in_word_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_valid && bus_tsize != 3'd0) |-> (bus_lanes[7:4] == 4'h0 || bus_lanes[3:0] == 4'h0));

  assert_refuse_quiet_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (rsp_valid && rsp_align_err) |-> $past(accept));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_valid |=> !rsp_valid);

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    accept |=> !req_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_tsize)
                                   && $stable(bus_lanes) && $stable(bus_wdata)));
endmodule

// File: tb/bus_size_splitter_tb_top.sv
`timescale 1ns/1ps
module bus_size_splitter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_fp;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        rsp_valid, rsp_align_err;
  logic [63:0] rsp_rdata;
  logic        bus_valid, bus_ready, bus_write;
  logic [31:0] bus_addr;
  logic [2:0]  bus_tsize;
  logic [7:0]  bus_lanes;
  logic [63:0] bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  bus_size_splitter #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_fp(req_fp), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_align_err(rsp_align_err), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_tsize(bus_tsize), .bus_lanes(bus_lanes),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int nbeats, lat, hold_err, seq;
  logic [7:0]  bus_mem [256];
  logic [7:0]  ref_mem [256];
  logic [31:0] bt_addr [4];
  logic [2:0]  bt_size [4];
  logic [7:0]  bt_lanes[4];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] lane_mask(input int cnt, input int lane);
    return 8'((16'((1 << cnt) - 1)) << lane);
  endfunction

  // bus responder with a per-case latency
  initial begin : responder
    int wcnt;
    bit snap_v;
    logic [31:0] sa;
    logic [7:0]  sl;
    logic [63:0] sw;
    wcnt = 0; snap_v = 0; sa = '0; sl = '0; sw = '0;
    bus_ready = 1'b0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      bus_ready = 1'b0;
      if (bus_valid) begin
        if (snap_v && (bus_addr != sa || bus_lanes != sl || bus_wdata != sw)) hold_err++;
        if (wcnt < lat) begin
          wcnt++; snap_v = 1; sa = bus_addr; sl = bus_lanes; sw = bus_wdata;
        end else begin
          wcnt = 0; snap_v = 0; bus_ready = 1'b1;
          if (nbeats < 4) begin
            bt_addr[nbeats] = bus_addr; bt_size[nbeats] = bus_tsize; bt_lanes[nbeats] = bus_lanes;
          end
          for (int i = 0; i < 8; i++) begin
            logic [7:0] ix;
            ix = {bus_addr[7:3], 3'b000} + 8'(i);
            bus_rdata[8*(7-i) +: 8] = bus_lanes[i] ? bus_mem[ix] : 8'hEE;
            if (bus_write && bus_lanes[i]) bus_mem[ix] = bus_wdata[8*(7-i) +: 8];
          end
          nbeats++;
        end
      end else snap_v = 0;
    end
  end

  task automatic run_access(input bit wr, input bit fp, input int sz, input logic [31:0] a,
                            input logic [63:0] wd, output logic [63:0] rd, output bit err,
                            output bit busy_ok, output bit pulse_ok);
    @(negedge clk);
    nbeats = 0;
    req_valid = 1'b1; req_write = wr; req_fp = fp; req_size = 2'(sz);
    req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1;
    while (!rsp_valid) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
    end
    if (req_ready) busy_ok = 0;
    rd = rsp_rdata; err = rsp_align_err;
    @(negedge clk);
    pulse_ok = !rsp_valid && req_ready;
  endtask

  // one access with all port-level checks against the expected transfer list
  task automatic access_chk(input bit wr, input bit fp, input int sz, input logic [31:0] a,
                            input logic [63:0] wd, output logic [63:0] rd);
    int n, off, h, exp_n;
    bit exp_err, err, busy_ok, pulse_ok, split;
    logic [31:0] a2;
    n = 1 << sz; off = int'(a[2:0]);
    exp_err = (fp || sz == 3) && (a[1:0] != 2'b00);
    split = (sz == 3) ? a[2] : (int'(a[1:0]) + n > 4);
    run_access(wr, fp, sz, a, wd, rd, err, busy_ok, pulse_ok);
    chk(err == exp_err, "R5 alignment flag", 64'(err), 64'(exp_err));
    chk(busy_ok, "R8 ready low while busy", 64'(busy_ok), 64'd1);
    chk(pulse_ok, "R7 one-cycle completion", 64'(pulse_ok), 64'd1);
    if (exp_err) begin
      chk(nbeats == 0, "R5 no bus transfer on refusal", 64'(nbeats), 64'd0);
    end else if (!split) begin
      exp_n = 1;
      chk(nbeats == exp_n, "R3 single transfer", 64'(nbeats), 64'(exp_n));
      chk(bt_addr[0] == a, "R2 transfer address", 64'(bt_addr[0]), 64'(a));
      chk(bt_size[0] == 3'(n), "R1 size code", 64'(bt_size[0]), 64'(3'(n)));
      chk(bt_lanes[0] == lane_mask(n, off), "R2 lane enables", 64'(bt_lanes[0]), 64'(lane_mask(n, off)));
    end else begin
      exp_n = 2;
      h = 4 - int'(a[1:0]);
      a2 = {a[31:2], 2'b00} + 32'd4;
      chk(nbeats == exp_n, "R4 two transfers", 64'(nbeats), 64'(exp_n));
      chk(bt_addr[0] == a, "R4 head address", 64'(bt_addr[0]), 64'(a));
      chk(bt_size[0] == 3'(h), "R1 head size code", 64'(bt_size[0]), 64'(3'(h)));
      chk(bt_lanes[0] == lane_mask(h, off), "R4 head lanes", 64'(bt_lanes[0]), 64'(lane_mask(h, off)));
      chk(bt_addr[1] == a2, "R4 tail address", 64'(bt_addr[1]), 64'(a2));
      chk(bt_size[1] == 3'(n - h), "R1 tail size code", 64'(bt_size[1]), 64'(3'(n - h)));
      chk(bt_lanes[1] == lane_mask(n - h, int'(a2[2:0])), "R4 tail lanes",
          64'(bt_lanes[1]), 64'(lane_mask(n - h, int'(a2[2:0]))));
    end
  endtask

  function automatic logic [63:0] ref_read(input int sz, input logic [31:0] a);
    logic [63:0] v;
    int n;
    n = 1 << sz; v = '0;
    for (int j = 0; j < n; j++) v[8*(n-1-j) +: 8] = ref_mem[8'(a + 32'(j))];
    return v;
  endfunction

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!req_ready && !bus_valid && !rsp_valid, "R10 outputs low in reset",
        {61'd0, req_ready, bus_valid, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready, "R10 ready after release", 64'(req_ready), 64'd1);
  endtask

  // every size at every offset: store then load back
  task automatic test_int_sweep();
    logic [63:0] rd, wd, exp;
    logic [31:0] a;
    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < 8; off++) begin
        a = 32'h40 + 32'(sz) * 32'h10 + 32'(off);
        lat = off % 3;
        seq++;
        for (int k = 0; k < 8; k++) wd[8*k +: 8] = 8'(seq * 7 + k * 16 + 1);
        access_chk(1'b1, 1'b0, sz, a, wd, rd);
        if (!(sz == 3 && a[1:0] != 2'b00))
          for (int j = 0; j < (1 << sz); j++)
            ref_mem[8'(a + 32'(j))] = wd[8*((1 << sz) - 1 - j) +: 8];
        access_chk(1'b0, 1'b0, sz, a, '0, rd);
        exp = (sz == 3 && a[1:0] != 2'b00) ? 64'd0 : ref_read(sz, a);
        chk(rd == exp, "R6 R7 read-back of stored operand", rd, exp);
      end
    end
  endtask

  // plain loads of untouched memory, all sizes and offsets
  task automatic test_load_sweep();
    logic [63:0] rd, exp;
    logic [31:0] a;
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 8; off++) begin
        a = 32'hA0 + 32'(off);
        lat = (off + sz) % 2;
        access_chk(1'b0, 1'b0, sz, a, '0, rd);
        exp = ref_read(sz, a);
        chk(rd == exp, "R7 load assembly", rd, exp);
      end
    end
  endtask

  // floating-point operands: word alignment required, refused ones leave memory alone
  task automatic test_fp_sweep();
    logic [63:0] rd, exp;
    logic [31:0] a;
    for (int sz = 2; sz < 4; sz++) begin
      for (int off = 0; off < 8; off++) begin
        a = 32'hC0 + 32'(off);
        lat = 1;
        access_chk(1'b1, 1'b1, sz, a, 64'hFFFF_FFFF_FFFF_FFFF, rd);
        if (a[1:0] == 2'b00)
          for (int j = 0; j < (1 << sz); j++) ref_mem[8'(a + 32'(j))] = 8'hFF;
        access_chk(1'b0, 1'b0, 0, a, '0, rd);
        exp = ref_read(0, a);
        chk(rd == exp, "R5 memory after floating-point store", rd, exp);
      end
    end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    nbeats = 0; lat = 0; hold_err = 0; seq = 0;
    req_valid = 1'b0; req_write = 1'b0; req_fp = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0;
    for (int i = 0; i < 256; i++) begin
      bus_mem[i] = 8'(i * 3 + 5);
      ref_mem[i] = 8'(i * 3 + 5);
    end
    test_reset();
    test_int_sweep();
    test_load_sweep();
    test_fp_sweep();
    chk(hold_err == 0, "R9 transfer held while waiting", 64'(hold_err), 64'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule